// File: doc/BRIEF.md
# Interrupt Request Acceptance and Dispatch

This block takes interrupt requests one at a time. Each request carries an 8-bit vector, a 3-bit delivery mode and a level/edge flag. The block files each request by its mode. Fixed and lowest-priority requests go into a 256-bit vectored request register. A 256-bit trigger-mode register sits beside it, and a running "highest requested vector" register is kept as well. System-management, non-maskable, init and external requests each go into their own one-deep latch, and each latch holds the vector that came with its request. Reserved mode encodings are dropped.

A consumer sees one pending interrupt at a time on the service outputs. Special latches come first, in a fixed order, then the external latch, then the highest vectored request. The consumer takes the presented interrupt with a one-cycle acknowledge. That clears the special latch, or moves the vectored bit from the request register into a 256-bit in-service register.

Top module: `irq_accept_top`

## Requirements
- R1: A request with mode 0 (fixed) or 1 (lowest-priority) sets bit `req_vector` of `req_bits` on the clock edge where `req_valid` is high.
- R2: When such a request finds its `req_bits` bit clear, bit `req_vector` of `trig_bits` becomes `req_level` (1 level, 0 edge). When the bit is already set, that `trig_bits` bit keeps its value.
- R3: `top_req_vector` takes the incoming vectored request's vector whenever it is larger than the current value. It never decreases before reset.
- R4: Modes 2 (SMI), 4 (NMI), 5 (INIT) and 7 (external) each have a latch. A request of that mode captures its vector only while the latch is empty. A further request of the same mode while the latch is pending is dropped, and the held vector is kept.
- R5: `urgent_pend` is high exactly when an SMI, NMI or INIT latch is pending. An external request does not raise it.
- R6: Modes 3 and 6 are reserved. Such a request changes no register and no output.
- R7: The service outputs present SMI, then NMI, then INIT, then external, then the highest set `req_bits` bit. `svc_kind` codes these as 1 SMI, 2 NMI, 3 INIT, 4 external, 5 vectored and 0 none. `svc_valid` is high whenever `svc_kind` is not 0.
- R8: `svc_ack` while a special or external interrupt is presented empties that latch. `urgent_pend` then follows the remaining SMI, NMI and INIT latches.
- R9: `svc_ack` while a vectored interrupt is presented clears that bit of `req_bits` and sets the same bit of `isr_bits`.
- R10: Reset clears all latches, captured vectors, `req_bits`, `trig_bits`, `isr_bits` and `top_req_vector`, so `svc_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_vector | input | 8 | Request vector |
| req_mode | input | 3 | Delivery mode of the request |
| req_level | input | 1 | 1 level-triggered, 0 edge-triggered |
| svc_valid | output | 1 | An interrupt is presented |
| svc_kind | output | 3 | Class of the presented interrupt |
| svc_vector | output | 8 | Vector of the presented interrupt |
| svc_ack | input | 1 | Consumer takes the presented interrupt |
| urgent_pend | output | 1 | Some SMI, NMI or INIT latch is pending |
| top_req_vector | output | 8 | Highest vectored request seen since reset |
| req_bits | output | 256 | Vectored request register |
| trig_bits | output | 256 | Trigger-mode register |
| isr_bits | output | 256 | In-service register |

## Verification
The hardest situation to reach is having all four latches and several vectored bits pending at the same time, so that every step of the dispatch order can be seen. The stimulus fills every latch first, including a second SMI that must be dropped, and adds vectored requests at both ends of the vector range. Each expected interrupt is queued in order. The acknowledges then drain the block one interrupt at a time, and after each one the latch flags, the request register and the in-service register are checked.

// File: rtl/irq_pkg.sv
package irq_pkg;

    typedef enum logic [2:0] {
        DM_FIXED  = 3'd0,
        DM_LOWPRI = 3'd1,
        DM_SMI    = 3'd2,
        DM_RSV3   = 3'd3,
        DM_NMI    = 3'd4,
        DM_INIT   = 3'd5,
        DM_RSV6   = 3'd6,
        DM_EXT    = 3'd7
    } dmode_e;

    typedef enum logic [2:0] {
        SK_NONE = 3'd0,
        SK_SMI  = 3'd1,
        SK_NMI  = 3'd2,
        SK_INIT = 3'd3,
        SK_EXT  = 3'd4,
        SK_VEC  = 3'd5
    } svc_kind_e;

    localparam int NUM_SLOTS = 4;
    localparam int SL_SMI    = 0;
    localparam int SL_NMI    = 1;
    localparam int SL_INIT   = 2;
    localparam int SL_EXT    = 3;

endpackage

// File: rtl/irq_special_latch.sv
module irq_special_latch #(
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_i,
    input  logic [VEC_W-1:0] vec_i,
    input  logic             clr_i,
    output logic             pend_o,
    output logic [VEC_W-1:0] vec_o
);

    typedef struct packed {
        logic             pend;
        logic [VEC_W-1:0] vec;
    } slot_t;

    slot_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.pend = 1'b0;
        end
        if (set_i && !st_d.pend) begin
            st_d.pend = 1'b1;
            st_d.vec  = vec_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_o = st_q.pend;
    assign vec_o  = st_q.vec;

    AST_SLOT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o && set_i && !clr_i) |=> (pend_o && $stable(vec_o))); // R4

    AST_SLOT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !pend_o); // R8

endmodule

// File: rtl/irq_prio_encoder.sv
module irq_prio_encoder #(
    parameter int W     = 256,
    parameter int IDX_W = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]     bits_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o
);

    always_comb begin
        any_o = 1'b0;
        idx_o = '0;
        for (int i = 0; i < W; i++) begin
            if (bits_i[i]) begin
                any_o = 1'b1;
                idx_o = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/irq_vec_store.sv
module irq_vec_store #(
    parameter int VEC_W = 8,
    localparam int NVEC = 1 << VEC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_i,
    input  logic [VEC_W-1:0] set_vec_i,
    input  logic             set_level_i,
    input  logic             ack_i,
    output logic [NVEC-1:0]  req_o,
    output logic [NVEC-1:0]  trig_o,
    output logic [NVEC-1:0]  isr_o,
    output logic [VEC_W-1:0] hi_o,
    output logic             any_o,
    output logic [VEC_W-1:0] top_o
);

    typedef struct packed {
        logic [NVEC-1:0]  req;
        logic [NVEC-1:0]  trig;
        logic [NVEC-1:0]  isr;
        logic [VEC_W-1:0] hi;
    } store_t;

    store_t st_d, st_q;

    irq_prio_encoder #(.W(NVEC), .IDX_W(VEC_W)) u_top_enc (
        .bits_i (st_q.req),
        .any_o  (any_o),
        .idx_o  (top_o)
    );

    always_comb begin
        st_d = st_q;
        if (ack_i && any_o) begin
            st_d.req[top_o] = 1'b0;
            st_d.isr[top_o] = 1'b1;
        end
        if (set_i) begin
            if (!st_d.req[set_vec_i]) begin
                st_d.trig[set_vec_i] = set_level_i;
            end
            st_d.req[set_vec_i] = 1'b1;
            if (set_vec_i > st_q.hi) begin
                st_d.hi = set_vec_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_o  = st_q.req;
    assign trig_o = st_q.trig;
    assign isr_o  = st_q.isr;
    assign hi_o   = st_q.hi;

    AST_REQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> req_o[$past(set_vec_i)]); // R1

    AST_TRIG_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i && req_o[set_vec_i] && !ack_i) |=>
        (trig_o[$past(set_vec_i)] == $past(trig_o[set_vec_i]))); // R2

    AST_HI_MONO: assert property (@(posedge clk) disable iff (!rst_n)
        !set_i |=> $stable(hi_o)); // R3

    AST_HI_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> (hi_o >= $past(set_vec_i))); // R3

endmodule

// File: rtl/irq_dispatch_arbiter.sv
module irq_dispatch_arbiter
    import irq_pkg::*;
#(
    parameter int VEC_W = 8
) (
    input  logic [NUM_SLOTS-1:0]            pend_i,
    input  logic [NUM_SLOTS-1:0][VEC_W-1:0] slot_vec_i,
    input  logic                            vec_any_i,
    input  logic [VEC_W-1:0]                vec_top_i,
    input  logic                            ack_i,
    output svc_kind_e                       kind_o,
    output logic [VEC_W-1:0]                vec_o,
    output logic [NUM_SLOTS-1:0]            slot_clr_o,
    output logic                            vec_ack_o
);

    logic urgent;
    assign urgent = pend_i[SL_SMI] | pend_i[SL_NMI] | pend_i[SL_INIT];

    always_comb begin
        kind_o     = SK_NONE;
        vec_o      = '0;
        slot_clr_o = '0;
        vec_ack_o  = 1'b0;
        if (urgent) begin
            if (pend_i[SL_SMI]) begin
                kind_o             = SK_SMI;
                vec_o              = slot_vec_i[SL_SMI];
                slot_clr_o[SL_SMI] = ack_i;
            end else if (pend_i[SL_NMI]) begin
                kind_o             = SK_NMI;
                vec_o              = slot_vec_i[SL_NMI];
                slot_clr_o[SL_NMI] = ack_i;
            end else begin
                kind_o              = SK_INIT;
                vec_o               = slot_vec_i[SL_INIT];
                slot_clr_o[SL_INIT] = ack_i;
            end
        end else if (pend_i[SL_EXT]) begin
            kind_o             = SK_EXT;
            vec_o              = slot_vec_i[SL_EXT];
            slot_clr_o[SL_EXT] = ack_i;
        end else if (vec_any_i) begin
            kind_o    = SK_VEC;
            vec_o     = vec_top_i;
            vec_ack_o = ack_i;
        end
    end

endmodule

// File: rtl/irq_accept_top.sv
module irq_accept_top
    import irq_pkg::*;
#(
    parameter int VEC_W = 8,
    localparam int NVEC = 1 << VEC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [VEC_W-1:0] req_vector,
    input  logic [2:0]       req_mode,
    input  logic             req_level,
    output logic             svc_valid,
    output logic [2:0]       svc_kind,
    output logic [VEC_W-1:0] svc_vector,
    input  logic             svc_ack,
    output logic             urgent_pend,
    output logic [VEC_W-1:0] top_req_vector,
    output logic [NVEC-1:0]  req_bits,
    output logic [NVEC-1:0]  trig_bits,
    output logic [NVEC-1:0]  isr_bits
);

    dmode_e                          mode;
    logic                            vec_set;
    logic [NUM_SLOTS-1:0]            slot_set;
    logic [NUM_SLOTS-1:0]            slot_clr;
    logic [NUM_SLOTS-1:0]            slot_pend;
    logic [NUM_SLOTS-1:0][VEC_W-1:0] slot_vec;
    logic                            vec_any;
    logic [VEC_W-1:0]                vec_top;
    logic                            vec_ack;
    svc_kind_e                       kind;

    assign mode = dmode_e'(req_mode);

    always_comb begin
        vec_set  = 1'b0;
        slot_set = '0;
        if (req_valid) begin
            unique case (mode)
                DM_FIXED, DM_LOWPRI: vec_set          = 1'b1;
                DM_SMI:              slot_set[SL_SMI]  = 1'b1;
                DM_NMI:              slot_set[SL_NMI]  = 1'b1;
                DM_INIT:             slot_set[SL_INIT] = 1'b1;
                DM_EXT:              slot_set[SL_EXT]  = 1'b1;
                default: ;
            endcase
        end
    end

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        irq_special_latch #(.VEC_W(VEC_W)) u_slot (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (slot_set[g]),
            .vec_i  (req_vector),
            .clr_i  (slot_clr[g]),
            .pend_o (slot_pend[g]),
            .vec_o  (slot_vec[g])
        );
    end

    irq_vec_store #(.VEC_W(VEC_W)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .set_i       (vec_set),
        .set_vec_i   (req_vector),
        .set_level_i (req_level),
        .ack_i       (vec_ack),
        .req_o       (req_bits),
        .trig_o      (trig_bits),
        .isr_o       (isr_bits),
        .hi_o        (top_req_vector),
        .any_o       (vec_any),
        .top_o       (vec_top)
    );

    irq_dispatch_arbiter #(.VEC_W(VEC_W)) u_arb (
        .pend_i     (slot_pend),
        .slot_vec_i (slot_vec),
        .vec_any_i  (vec_any),
        .vec_top_i  (vec_top),
        .ack_i      (svc_ack),
        .kind_o     (kind),
        .vec_o      (svc_vector),
        .slot_clr_o (slot_clr),
        .vec_ack_o  (vec_ack)
    );

    assign svc_kind    = kind;
    assign svc_valid   = (kind != SK_NONE);
    assign urgent_pend = slot_pend[SL_SMI] | slot_pend[SL_NMI] | slot_pend[SL_INIT];

    AST_RSV_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_mode == 3'd3 || req_mode == 3'd6) && !svc_ack) |=>
        ($stable(req_bits) && $stable(trig_bits) && $stable(svc_kind) &&
         $stable(svc_vector) && $stable(urgent_pend))); // R6

    AST_URGENT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        urgent_pend |-> (svc_kind == 3'd1 || svc_kind == 3'd2 || svc_kind == 3'd3)); // R7

    AST_EXT_NOT_URGENT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_mode == 3'd7 && !urgent_pend) |=> !urgent_pend); // R5

    AST_ISR_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_ack && svc_kind == 3'd5 && !(req_valid && req_vector == svc_vector)) |=>
        (isr_bits[$past(svc_vector)] && !req_bits[$past(svc_vector)])); // R9

    AST_RESET_IDLE: assert property (@(posedge clk)
        $past(!rst_n) |-> (!svc_valid && req_bits == '0 && isr_bits == '0)); // R10

endmodule

// File: tb/irq_accept_top_tb_top.sv
module irq_accept_top_tb_top;

    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         req_valid;
    logic [7:0]   req_vector;
    logic [2:0]   req_mode;
    logic         req_level;
    logic         svc_valid;
    logic [2:0]   svc_kind;
    logic [7:0]   svc_vector;
    logic         svc_ack;
    logic         urgent_pend;
    logic [7:0]   top_req_vector;
    logic [255:0] req_bits;
    logic [255:0] trig_bits;
    logic [255:0] isr_bits;

    int n_checks = 0;
    int n_errors = 0;

    typedef struct {
        logic [2:0] kind;
        logic [7:0] vec;
    } exp_t;

    exp_t sbq[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    irq_accept_top dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_valid      (req_valid),
        .req_vector     (req_vector),
        .req_mode       (req_mode),
        .req_level      (req_level),
        .svc_valid      (svc_valid),
        .svc_kind       (svc_kind),
        .svc_vector     (svc_vector),
        .svc_ack        (svc_ack),
        .urgent_pend    (urgent_pend),
        .top_req_vector (top_req_vector),
        .req_bits       (req_bits),
        .trig_bits      (trig_bits),
        .isr_bits       (isr_bits)
    );

    task automatic check(string tag, logic [255:0] act, logic [255:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send(logic [2:0] m, logic [7:0] v, logic lvl);
        @(negedge clk);
        req_valid  = 1'b1;
        req_mode   = m;
        req_vector = v;
        req_level  = lvl;
        @(negedge clk);
        req_valid  = 1'b0;
    endtask

    task automatic push_exp(logic [2:0] k, logic [7:0] v);
        exp_t e;
        e.kind = k;
        e.vec  = v;
        sbq.push_back(e);
    endtask

    // monitor side: compare the presented interrupt with the queue head, then take it
    task automatic take_one(string tag);
        exp_t e;
        e = sbq.pop_front();
        check({tag, " svc_kind"}, 256'(svc_kind), 256'(e.kind));
        check({tag, " svc_vector"}, 256'(svc_vector), 256'(e.vec));
        svc_ack = 1'b1;
        @(negedge clk);
        svc_ack = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        rst_n      = 1'b0;
        req_valid  = 1'b0;
        req_vector = '0;
        req_mode   = '0;
        req_level  = 1'b0;
        svc_ack    = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        check("R10 svc_valid", 256'(svc_valid), 256'(0));
        check("R10 req_bits", req_bits, '0);
        check("R10 trig_bits", trig_bits, '0);
        check("R10 isr_bits", isr_bits, '0);
        check("R10 top", 256'(top_req_vector), 256'(0));

        // R1 R2 R3: fixed, level
        send(3'd0, 8'h20, 1'b1);
        check("R1 req bit 0x20", 256'(req_bits[8'h20]), 256'(1));
        check("R2 trig level 0x20", 256'(trig_bits[8'h20]), 256'(1));
        check("R3 top 0x20", 256'(top_req_vector), 256'(8'h20));
        check("R7 vectored shown", 256'({svc_valid, svc_kind, svc_vector}), 256'({1'b1, 3'd5, 8'h20}));

        // R2: repeat as lowest-priority edge keeps trigger bit
        send(3'd1, 8'h20, 1'b0);
        check("R2 trig kept 0x20", 256'(trig_bits[8'h20]), 256'(1));

        // R2 R3: smaller edge request
        send(3'd0, 8'h10, 1'b0);
        check("R1 req bit 0x10", 256'(req_bits[8'h10]), 256'(1));
        check("R2 trig edge 0x10", 256'(trig_bits[8'h10]), 256'(0));
        check("R3 top kept", 256'(top_req_vector), 256'(8'h20));

        // R6 reserved modes
        send(3'd3, 8'h50, 1'b1);
        send(3'd6, 8'h60, 1'b1);
        check("R6 req_bits", req_bits, (256'(1) << 8'h20) | (256'(1) << 8'h10));
        check("R6 top", 256'(top_req_vector), 256'(8'h20));
        check("R6 urgent", 256'(urgent_pend), 256'(0));
        check("R6 svc", 256'({svc_kind, svc_vector}), 256'({3'd5, 8'h20}));

        // R5 external does not raise urgent
        send(3'd7, 8'h33, 1'b0);
        check("R5 urgent after ext", 256'(urgent_pend), 256'(0));
        check("R7 ext shown", 256'({svc_kind, svc_vector}), 256'({3'd4, 8'h33}));

        // R4 R5: fill special latches, second SMI dropped, vectored range ends
        send(3'd5, 8'h44, 1'b0);
        send(3'd4, 8'h02, 1'b0);
        send(3'd2, 8'h05, 1'b0);
        send(3'd2, 8'h07, 1'b0);
        send(3'd7, 8'h99, 1'b0);
        send(3'd0, 8'hFF, 1'b1);
        send(3'd1, 8'h00, 1'b0);
        check("R5 urgent set", 256'(urgent_pend), 256'(1));
        check("R3 top 0xFF", 256'(top_req_vector), 256'(8'hFF));

        push_exp(3'd1, 8'h05);
        push_exp(3'd2, 8'h02);
        push_exp(3'd3, 8'h44);
        push_exp(3'd4, 8'h33);
        push_exp(3'd5, 8'hFF);
        push_exp(3'd5, 8'h20);
        push_exp(3'd5, 8'h10);
        push_exp(3'd5, 8'h00);

        take_one("R4 R7 smi kept first vector");
        check("R8 urgent after smi ack", 256'(urgent_pend), 256'(1));
        take_one("R7 nmi");
        take_one("R7 init");
        check("R8 urgent after init ack", 256'(urgent_pend), 256'(0));
        take_one("R4 R7 ext kept first vector");
        take_one("R7 vec FF");
        check("R9 isr FF", 256'(isr_bits[8'hFF]), 256'(1));
        check("R9 req FF cleared", 256'(req_bits[8'hFF]), 256'(0));
        take_one("R7 vec 20");
        take_one("R7 vec 10");
        take_one("R7 vec 00");
        check("R9 isr all", isr_bits,
              (256'(1) << 8'hFF) | (256'(1) << 8'h20) | (256'(1) << 8'h10) | 256'(1));
        check("R9 req empty", req_bits, '0);
        check("R8 svc idle", 256'(svc_valid), 256'(0));
        check("R3 top held", 256'(top_req_vector), 256'(8'hFF));

        // R8: latch reusable after ack
        send(3'd2, 8'h09, 1'b0);
        push_exp(3'd1, 8'h09);
        take_one("R8 smi reaccepted");
        check("R8 urgent clear", 256'(urgent_pend), 256'(0));

        // R10 reset with state present
        send(3'd4, 8'h11, 1'b0);
        send(3'd0, 8'h80, 1'b1);
        do_reset();
        @(negedge clk);
        check("R10 post svc_valid", 256'(svc_valid), 256'(0));
        check("R10 post urgent", 256'(urgent_pend), 256'(0));
        check("R10 post req", req_bits, '0);
        check("R10 post trig", trig_bits, '0);
        check("R10 post isr", isr_bits, '0);
        check("R10 post top", 256'(top_req_vector), 256'(0));

        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule